// File: doc/BRIEF.md
# Power-State Control Register with Request Gating

This block holds the power-management state of an interrupt-controller function and uses that state to decide which incoming requests the function answers. Software reads and writes the register through a 32-bit configuration port that has per-byte write enables. Only two power states are supported: full-on (D0) and the low-power hot state (D3hot). A write that asks for either of the two intermediate states is ignored.

Each cycle, the surrounding logic presents one transaction descriptor. The descriptor gives the transaction kind, the memory region it targets and whether the alternate region is enabled. The block answers in the same cycle with accept or drop. It also passes or blocks MSI requests. In D3hot, the block still answers Type 0 configuration accesses. It also answers the alternate memory region, but only while that region is enabled. The main memory region, other configuration kinds and MSI writes are all shut off in D3hot.

Top module: `pm_power_gate`

## Requirements
- R1: After reset the power state is 00 (D0) and `cfg_rdata_o` reads 0x0000_0008.
- R2: A write with `cfg_be_i[0]`=1 and `cfg_wdata_i[1:0]` equal to 00 (D0) or 11 (D3hot) sets the state. The new value is visible on `cfg_rdata_o[1:0]` from the next clock edge.
- R3: A write with `cfg_wdata_i[1:0]` equal to 01 or 10 leaves the state unchanged.
- R4: A write with `cfg_be_i[0]`=0 leaves the state unchanged.
- R5: Bit 3 always reads 1 and all bits above bit 1, other than bit 3, always read 0, whatever is written.
- R6: In D0, transaction kinds 00 (config Type 0), 01 (config other) and 10 (memory) are accepted, except that memory with `tx_region_i`=1 (alternate) is accepted only when `alt_en_i`=1. Kind 11 is never accepted.
- R7: In D3hot, kind 00 is accepted and kind 01 is dropped.
- R8: In D3hot, a memory access with `tx_region_i`=0 (main) is dropped. A memory access with `tx_region_i`=1 is accepted only when `alt_en_i`=1.
- R9: `msi_issue_o` follows `msi_req_i` in D0. In D3hot, `msi_issue_o` stays 0 and `msi_drop_o` follows `msi_req_i`, so one request cycle gives one drop cycle.
- R10: A transaction or MSI request in the same cycle as a state write is judged by the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Register read value |
| tx_valid_i | input | 1 | Transaction descriptor valid |
| tx_kind_i | input | 2 | 00 config Type 0, 01 config other, 10 memory, 11 none |
| tx_region_i | input | 1 | Memory target: 0 main, 1 alternate |
| alt_en_i | input | 1 | Alternate region enabled |
| tx_accept_o | output | 1 | Transaction claimed |
| tx_drop_o | output | 1 | Valid transaction not claimed |
| msi_req_i | input | 1 | MSI write request |
| msi_issue_o | output | 1 | MSI write allowed out |
| msi_drop_o | output | 1 | MSI request discarded |

## Verification
The bench walks every combination of transaction kind, region and alternate-enable in both states. A design that applies D3hot gating to the alternate region, or that ignores its enable, would show the wrong accept result. The bench writes 01 and 10 from each legal state, and writes with lane 0 disabled. A design that stores raw write data would leave the legal pair of states. The bench writes all ones to the read-only fields; a design that stores those bits would read back other than 0xB. A write is driven in the same cycle as a main-region access and an MSI request. A design that bypasses the new state combinationally would drop that access one cycle early.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PS_D0   = 2'b00,
    PS_D1   = 2'b01,
    PS_D2   = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  typedef enum logic [1:0] {
    TK_CFG0  = 2'b00,
    TK_CFGX  = 2'b01,
    TK_MEM   = 2'b10,
    TK_NONE  = 2'b11
  } tx_kind_e;
endpackage

// File: rtl/pm_csr.sv
module pm_csr #(
  parameter int DATA_W = 32,
  parameter int NSR_BIT = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [DATA_W/8-1:0]  be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output pm_pkg::pstate_e      pstate_o,
  output logic [DATA_W-1:0]    rdata_o
);
  import pm_pkg::*;

  pstate_e state_q;
  logic    legal_wr;

  assign legal_wr = we_i && be_i[0] &&
                    (wdata_i[1:0] == PS_D0 || wdata_i[1:0] == PS_D3HOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= PS_D0;
    else if (legal_wr) state_q <= pstate_e'(wdata_i[1:0]);
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[1:0]     = state_q;
    rdata_o[NSR_BIT] = 1'b1;
  end

  assign pstate_o = state_q;

  a_r2_legal_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && be_i[0] && wdata_i[1:0] == 2'b11) |=> (pstate_o == PS_D3HOT));
  a_r3_unsupported_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i[1:0] == 2'b01 || wdata_i[1:0] == 2'b10)) |=> $stable(pstate_o));
  a_r4_lane0_required: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !be_i[0]) |=> $stable(pstate_o));
endmodule

// File: rtl/pm_xact_filter.sv
module pm_xact_filter (
  input  pm_pkg::pstate_e  pstate_i,
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       kind_i,
  input  logic             region_i,
  input  logic             alt_en_i,
  output logic             accept_o,
  output logic             drop_o
);
  import pm_pkg::*;

  logic low_pwr;
  logic claim;

  assign low_pwr = (pstate_i == PS_D3HOT);

  always_comb begin
    unique case (tx_kind_e'(kind_i))
      TK_CFG0: claim = 1'b1;
      TK_CFGX: claim = !low_pwr;
      TK_MEM:  claim = region_i ? alt_en_i : !low_pwr;
      default: claim = 1'b0;
    endcase
  end

  assign accept_o = valid_i && claim;
  assign drop_o   = valid_i && !claim;

  a_r8_main_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_i == PS_D3HOT && kind_i == 2'b10 && !region_i) |-> !accept_o);
  a_r7_cfg_other_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_i == PS_D3HOT && kind_i == 2'b01) |-> !accept_o);
  a_r6_alt_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b10 && region_i && !alt_en_i) |-> !accept_o);
endmodule

// File: rtl/pm_msi_gate.sv
module pm_msi_gate (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pm_pkg::pstate_e  pstate_i,
  input  logic             req_i,
  output logic             issue_o,
  output logic             drop_o
);
  import pm_pkg::*;

  logic on;
  assign on      = (pstate_i == PS_D0);
  assign issue_o = req_i && on;
  assign drop_o  = req_i && !on;

  a_r9_no_msi_in_d3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_i == PS_D3HOT) |-> !issue_o);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({issue_o, drop_o}));
endmodule

// File: rtl/pm_power_gate.sv
module pm_power_gate #(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              tx_valid_i,
  input  logic [1:0]        tx_kind_i,
  input  logic              tx_region_i,
  input  logic              alt_en_i,
  output logic              tx_accept_o,
  output logic              tx_drop_o,
  input  logic              msi_req_i,
  output logic              msi_issue_o,
  output logic              msi_drop_o
);
  import pm_pkg::*;

  pstate_e pstate;

  pm_csr #(.DATA_W(DATA_W), .NSR_BIT(3)) u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .be_i     (cfg_be_i),
    .wdata_i  (cfg_wdata_i),
    .pstate_o (pstate),
    .rdata_o  (cfg_rdata_o)
  );

  pm_xact_filter u_filt (
    .pstate_i (pstate),
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (tx_valid_i),
    .kind_i   (tx_kind_i),
    .region_i (tx_region_i),
    .alt_en_i (alt_en_i),
    .accept_o (tx_accept_o),
    .drop_o   (tx_drop_o)
  );

  pm_msi_gate u_msi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pstate_i (pstate),
    .req_i    (msi_req_i),
    .issue_o  (msi_issue_o),
    .drop_o   (msi_drop_o)
  );

  a_r10_old_state_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_be_i[0] && cfg_wdata_i[1:0] == 2'b11 && pstate == PS_D0 && msi_req_i)
      |-> msi_issue_o);
  a_r5_nsr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[3] && cfg_rdata_o[DATA_W-1:4] == '0 && !cfg_rdata_o[2]);
endmodule

// File: tb/pm_power_gate_tb_top.sv
module pm_power_gate_tb_top;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        cfg_we_i = 0;
  logic [3:0]  cfg_be_i = 0;
  logic [31:0] cfg_wdata_i = 0;
  logic [31:0] cfg_rdata_o;
  logic        tx_valid_i = 0;
  logic [1:0]  tx_kind_i = 0;
  logic        tx_region_i = 0;
  logic        alt_en_i = 0;
  logic        tx_accept_o, tx_drop_o;
  logic        msi_req_i = 0;
  logic        msi_issue_o, msi_drop_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  pm_power_gate dut_i (.*);

  // {state[1:0], kind[1:0], region, alt_en, expected accept}
  localparam logic [6:0] VEC [12] = '{
    {2'b00, 2'b00, 1'b0, 1'b0, 1'b1},
    {2'b00, 2'b01, 1'b0, 1'b0, 1'b1},
    {2'b00, 2'b10, 1'b0, 1'b0, 1'b1},
    {2'b00, 2'b10, 1'b1, 1'b1, 1'b1},
    {2'b00, 2'b10, 1'b1, 1'b0, 1'b0},
    {2'b00, 2'b11, 1'b0, 1'b1, 1'b0},
    {2'b11, 2'b00, 1'b0, 1'b0, 1'b1},
    {2'b11, 2'b01, 1'b0, 1'b0, 1'b0},
    {2'b11, 2'b10, 1'b0, 1'b0, 1'b0},
    {2'b11, 2'b10, 1'b1, 1'b1, 1'b1},
    {2'b11, 2'b10, 1'b1, 1'b0, 1'b0},
    {2'b11, 2'b10, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0; cfg_be_i = 0; cfg_wdata_i = 0;
  endtask

  initial begin
    #500us;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #12 rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset value", cfg_rdata_o, 32'h8);

    for (int i = 0; i < 12; i++) begin
      string tag;
      cfg_write(4'h1, {30'b0, VEC[i][6:5]});
      @(negedge clk_i);
      tx_valid_i = 1; tx_kind_i = VEC[i][4:3];
      tx_region_i = VEC[i][2]; alt_en_i = VEC[i][1];
      #1;
      tag = (VEC[i][6:5] == 2'b00) ? "R6 D0 accept" :
            (VEC[i][4:3] == 2'b10) ? "R8 D3hot memory" : "R7 D3hot config";
      check(tag, {31'b0, tx_accept_o}, {31'b0, VEC[i][0]});
      check(tag, {31'b0, tx_drop_o}, {31'b0, ~VEC[i][0]});
      tx_valid_i = 0;
    end

    // state is D3hot here
    cfg_write(4'h1, 32'h1);
    check("R3 write 01 from D3hot", cfg_rdata_o, 32'hB);
    cfg_write(4'h1, 32'h2);
    check("R3 write 10 from D3hot", cfg_rdata_o, 32'hB);
    cfg_write(4'hE, 32'h0);
    check("R4 lane0 disabled", cfg_rdata_o, 32'hB);
    cfg_write(4'h1, 32'h0);
    check("R2 write D0", cfg_rdata_o, 32'h8);
    cfg_write(4'h1, 32'h2);
    check("R3 write 10 from D0", cfg_rdata_o, 32'h8);
    cfg_write(4'h1, 32'h1);
    check("R3 write 01 from D0", cfg_rdata_o, 32'h8);
    cfg_write(4'hF, 32'hFFFF_FFFF);
    check("R5 all ones", cfg_rdata_o, 32'hB);
    cfg_write(4'hF, 32'hFFFF_FFF4);
    check("R5 ones above, D0 below", cfg_rdata_o, 32'h8);

    // R9 MSI in D0
    @(negedge clk_i); msi_req_i = 1; #1;
    check("R9 D0 issue", {31'b0, msi_issue_o}, 32'h1);
    check("R9 D0 no drop", {31'b0, msi_drop_o}, 32'h0);
    @(negedge clk_i); msi_req_i = 0;

    // R10 write D3hot with traffic in the same cycle
    @(negedge clk_i);
    cfg_we_i = 1; cfg_be_i = 4'h1; cfg_wdata_i = 32'h3;
    tx_valid_i = 1; tx_kind_i = 2'b10; tx_region_i = 0; alt_en_i = 0;
    msi_req_i = 1;
    #1;
    check("R10 old state accept", {31'b0, tx_accept_o}, 32'h1);
    check("R10 old state msi", {31'b0, msi_issue_o}, 32'h1);
    @(negedge clk_i);
    cfg_we_i = 0; cfg_be_i = 0; cfg_wdata_i = 0;
    #1;
    check("R8 main dropped after switch", {31'b0, tx_accept_o}, 32'h0);
    check("R9 D3hot no issue", {31'b0, msi_issue_o}, 32'h0);
    check("R9 D3hot drop", {31'b0, msi_drop_o}, 32'h1);
    @(negedge clk_i);
    msi_req_i = 0; tx_valid_i = 0;
    #1;
    check("R9 drop single pulse", {31'b0, msi_drop_o}, 32'h0);
    check("R2 read D3hot", cfg_rdata_o, 32'hB);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule